// File: doc/BRIEF.md
# Register Rename Stage with Reorder-Buffer Tags

This block renames a group of up to three micro-ops per clock. Integer and floating-point code have separate alias tables of eight architectural registers each. Every table entry says where the newest value of its register lives. It is either the retirement register file or a reorder-buffer slot, and the slot number is the operand tag handed to the scheduler. A group is accepted only when the reorder buffer, the reservation station and the load and store queues can all take every micro-op in it. If any of them cannot, nothing is taken. The slot numbers, the source tags and the ready bits come out one cycle later with a one-cycle valid pulse.

The incoming group uses a valid/ready handshake. The group on the pins is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends on the group offered and on the credits held, so the sender must keep the group stable until it is taken. The result side has no back-pressure: `out_valid` is a pulse and is never stalled. Retirement (`ret_en`), credit returns, `mispredict` and `core_drained` are plain control pins.

A retiring micro-op sends its register back to the retirement file only if the table still names that micro-op's slot. A mispredict stops renaming until the core reports it has drained. The block then points every entry back at the retirement file, empties the reorder-buffer ring and refills all credits, with no checkpoint to restore. Conflicts inside a group and between retirement and rename in the same cycle are resolved by bypass.

Top module: `rat_rename`

## Requirements
- R1: After reset every register of both files reads as ready (held in the retirement file), `out_valid` and `recovering` are low, and an empty group is offered `in_ready` high.
- R2: Each valid micro-op of an accepted group gets the next reorder-buffer slot number in lane order, starting at the ring tail and wrapping from ROB_DEPTH-1 to 0. Invalid lanes take no slot.
- R3: A source whose register maps to the retirement file reports ready=1. One that maps to a slot reports ready=0 and that slot's number as its tag.
- R4: A source that names the destination of an earlier valid lane in the same group, in the same file, reports ready=0 and that lane's slot number. The nearest earlier lane wins.
- R5: After a group is accepted, each written destination maps to the slot of its writer. When several lanes of a group write one register, the highest lane wins.
- R6: `in_ready` is high only when no recovery is in progress, `mispredict` is low, and the free slots in the reorder buffer and the reservation station are each at least the number of valid lanes. The load queue must also hold at least the number of loads and the store queue at least the number of stores. Lane memory code 2'b01 means load, 2'b10 means store, and 2'b00 means no queue entry. Otherwise nothing of the group is taken.
- R7: `ret_en` retires the oldest slot. Its destination reverts to the retirement file only if the entry still holds that slot number. `ret_en` with an empty ring has no effect.
- R8: When a retirement and a rename fall in the same cycle, a source reading the retiring register sees the retirement file. A rename that writes the same register wins over the clear.
- R9: `in_is_fp` picks the table for a lane's destination and both its sources. The same register index in the other file is unaffected.
- R10: `mispredict` raises `recovering` on the next edge and holds `in_ready` low from that cycle. `core_drained` while recovering resets both tables to the retirement file, empties the ring, refills all credits and clears `recovering` on the next edge. Retirement and credit returns in that cycle are ignored.
- R11: `out_valid` pulses exactly in the cycle after each accepted group, with `out_uop_vld` copying the lane valid bits.
- R12: `rs_release` returns that many reservation-station credits. `lb_release` and `sb_release` each return one load-queue or store-queue credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Rename group offered |
| in_ready | output | 1 | Group fits and renaming is allowed |
| in_uop_vld | input | G | Lane valid bits |
| in_is_fp | input | G | Lane uses the floating-point table |
| in_dst_en | input | G | Lane writes a destination |
| in_dst | input | G*RW | Destination register per lane |
| in_src_a | input | G*RW | First source register per lane |
| in_src_b | input | G*RW | Second source register per lane |
| in_mem | input | G*2 | Queue kind per lane (00 none, 01 load, 10 store) |
| ret_en | input | 1 | Retire the oldest slot |
| rs_release | input | GW | Reservation-station credits returned |
| lb_release | input | 1 | One load-queue credit returned |
| sb_release | input | 1 | One store-queue credit returned |
| mispredict | input | 1 | Branch mispredict, start recovery |
| core_drained | input | 1 | Core has drained, finish recovery |
| out_valid | output | 1 | Rename result pulse |
| out_uop_vld | output | G | Lane valid bits of the result |
| out_tag | output | G*TAG_W | Slot number per lane |
| out_a_tag | output | G*TAG_W | First source tag per lane |
| out_a_rdy | output | G | First source in retirement file |
| out_b_tag | output | G*TAG_W | Second source tag per lane |
| out_b_rdy | output | G | Second source in retirement file |
| recovering | output | 1 | Recovery in progress |

## Verification
Retirement and renaming can fall in the same cycle. The retiring slot's clear then meets a group that reads or rewrites the same register. The bench provokes this directly, and the random phase uses only eight registers per file with `ret_en` high half the time. A reference model applies the clear before the group's writes and lets reads see the cleared state, and the reported tags, ready bits and later lookups are judged against it. Allocation against a nearly full ring or queue, and a drain that lands while groups are still offered, are covered the same way.

// File: rtl/rat_pkg.sv
`timescale 1ns/1ps
package rat_pkg;
  typedef enum logic [1:0] {
    MEM_NONE  = 2'b00,
    MEM_LOAD  = 2'b01,
    MEM_STORE = 2'b10
  } mem_kind_e;

  function automatic int wrap_idx(input int base, input int inc, input int depth);
    int s;
    s = base + inc;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/rat_map_table.sv
`timescale 1ns/1ps
module rat_map_table #(
  parameter int NREG  = 8,
  parameter int TAG_W = 6,
  parameter int NWR   = 3,
  parameter int NRD   = 6,
  localparam int RW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_all,
  input  logic [NWR-1:0]     wr_en,
  input  logic [NWR*RW-1:0]  wr_reg,
  input  logic [NWR*TAG_W-1:0] wr_tag,
  input  logic               clr_en,
  input  logic [RW-1:0]      clr_reg,
  input  logic [TAG_W-1:0]   clr_tag,
  input  logic [NRD*RW-1:0]  rd_reg,
  output logic [NRD-1:0]     rd_inrob,
  output logic [NRD*TAG_W-1:0] rd_tag
);
  logic [NREG-1:0]  inrob_q, inrob_d;
  logic [TAG_W-1:0] tag_q [NREG];
  logic [TAG_W-1:0] tag_d [NREG];

  // next state: retirement clear first, then group writes in lane order
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      inrob_d[r] = inrob_q[r];
      tag_d[r]   = tag_q[r];
      if (clr_en && clr_reg == RW'(r) && inrob_q[r] && tag_q[r] == clr_tag)
        inrob_d[r] = 1'b0;
      for (int k = 0; k < NWR; k++) begin
        if (wr_en[k] && wr_reg[k*RW +: RW] == RW'(r)) begin
          inrob_d[r] = 1'b1;
          tag_d[r]   = wr_tag[k*TAG_W +: TAG_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inrob_q <= '0;
      for (int r = 0; r < NREG; r++) tag_q[r] <= '0;
    end else if (reset_all) begin
      inrob_q <= '0;
    end else begin
      inrob_q <= inrob_d;
      for (int r = 0; r < NREG; r++) tag_q[r] <= tag_d[r];
    end
  end

  // reads see a same-cycle retirement clear
  always_comb begin
    for (int i = 0; i < NRD; i++) begin
      rd_inrob[i] = inrob_q[rd_reg[i*RW +: RW]] &&
                    !(clr_en && clr_reg == rd_reg[i*RW +: RW] &&
                      tag_q[rd_reg[i*RW +: RW]] == clr_tag);
      rd_tag[i*TAG_W +: TAG_W] = tag_q[rd_reg[i*RW +: RW]];
    end
  end
endmodule

// File: rtl/rat_credit.sv
`timescale 1ns/1ps
module rat_credit #(
  parameter int DEPTH = 20,
  parameter int TW    = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refill,
  input  logic [TW-1:0] take,
  input  logic [TW-1:0] give,
  output logic [CW-1:0] avail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      avail <= CW'(DEPTH);
    else if (refill) avail <= CW'(DEPTH);
    else             avail <= avail - CW'(take) + CW'(give);
  end
endmodule

// File: rtl/rat_rob_ring.sv
`timescale 1ns/1ps
module rat_rob_ring import rat_pkg::*; #(
  parameter int DEPTH  = 40,
  parameter int G      = 3,
  parameter int INFO_W = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int GW    = $clog2(G + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [G-1:0]        alloc_we,
  input  logic [G*TAG_W-1:0]  alloc_tag,
  input  logic [G*INFO_W-1:0] alloc_info,
  input  logic [GW-1:0]       alloc_cnt,
  input  logic                ret_en,
  output logic [TAG_W-1:0]    tail,
  output logic [TAG_W-1:0]    head,
  output logic [CW-1:0]       count,
  output logic [INFO_W-1:0]   head_info,
  output logic                ret_fire
);
  logic [INFO_W-1:0] info_q [DEPTH];

  assign ret_fire  = ret_en && (count != '0) && !flush;
  assign head_info = info_q[head];

  always_ff @(posedge clk) begin
    for (int k = 0; k < G; k++)
      if (alloc_we[k]) info_q[alloc_tag[k*TAG_W +: TAG_W]] <= alloc_info[k*INFO_W +: INFO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= '0; head <= '0; count <= '0;
    end else if (flush) begin
      tail <= '0; head <= '0; count <= '0;
    end else begin
      tail  <= TAG_W'(wrap_idx(int'(tail), int'(alloc_cnt), DEPTH));
      head  <= ret_fire ? TAG_W'(wrap_idx(int'(head), 1, DEPTH)) : head;
      count <= count + CW'(alloc_cnt) - CW'(ret_fire);
    end
  end
endmodule

// File: rtl/rat_rename.sv
`timescale 1ns/1ps
module rat_rename import rat_pkg::*; #(
  parameter int G         = 3,
  parameter int ROB_DEPTH = 40,
  parameter int NREG      = 8,
  parameter int RS_DEPTH  = 20,
  parameter int LB_DEPTH  = 16,
  parameter int SB_DEPTH  = 12,
  localparam int TAG_W    = $clog2(ROB_DEPTH),
  localparam int RW       = $clog2(NREG),
  localparam int GW       = $clog2(G + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [G-1:0]       in_uop_vld,
  input  logic [G-1:0]       in_is_fp,
  input  logic [G-1:0]       in_dst_en,
  input  logic [G*RW-1:0]    in_dst,
  input  logic [G*RW-1:0]    in_src_a,
  input  logic [G*RW-1:0]    in_src_b,
  input  logic [G*2-1:0]     in_mem,
  input  logic               ret_en,
  input  logic [GW-1:0]      rs_release,
  input  logic               lb_release,
  input  logic               sb_release,
  input  logic               mispredict,
  input  logic               core_drained,
  output logic               out_valid,
  output logic [G-1:0]       out_uop_vld,
  output logic [G*TAG_W-1:0] out_tag,
  output logic [G*TAG_W-1:0] out_a_tag,
  output logic [G-1:0]       out_a_rdy,
  output logic [G*TAG_W-1:0] out_b_tag,
  output logic [G-1:0]       out_b_rdy,
  output logic               recovering
);
  localparam int RCW    = $clog2(ROB_DEPTH + 1);
  localparam int INFO_W = RW + 2;
  localparam int NRD    = 2 * G;
  localparam int RS_CW  = $clog2(RS_DEPTH + 1);
  localparam int LB_CW  = $clog2(LB_DEPTH + 1);
  localparam int SB_CW  = $clog2(SB_DEPTH + 1);

  logic [GW-1:0]        n_uops, n_ld, n_st;
  logic [G*TAG_W-1:0]   slot_tag;
  logic [TAG_W-1:0]     tail, head;
  logic [RCW-1:0]       rob_count;
  logic [INFO_W-1:0]    head_info;
  logic                 ret_fire, accept, flush, recovering_q, fits;
  logic [RS_CW-1:0]     rs_avail;
  logic [LB_CW-1:0]     lb_avail;
  logic [SB_CW-1:0]     sb_avail;
  logic [G*INFO_W-1:0]  alloc_info;
  logic [G-1:0]         alloc_we;
  logic [NRD*RW-1:0]    rd_reg;
  logic [NRD-1:0]       rd_inrob_f [2];
  logic [NRD*TAG_W-1:0] rd_tag_f   [2];
  logic [G-1:0]         wr_en_f    [2];
  logic [1:0]           clr_en_f;
  logic [NRD-1:0]       src_inrob;
  logic [NRD*TAG_W-1:0] src_tag;

  // group census and slot assignment
  always_comb begin
    int off;
    off = 0;
    n_uops = '0; n_ld = '0; n_st = '0;
    slot_tag = '0;
    for (int k = 0; k < G; k++) begin
      slot_tag[k*TAG_W +: TAG_W] = TAG_W'(wrap_idx(int'(tail), off, ROB_DEPTH));
      if (in_uop_vld[k]) begin
        off    = off + 1;
        n_uops = n_uops + GW'(1);
        if (in_mem[k*2 +: 2] == MEM_LOAD)  n_ld = n_ld + GW'(1);
        if (in_mem[k*2 +: 2] == MEM_STORE) n_st = n_st + GW'(1);
      end
    end
  end

  assign fits = (ROB_DEPTH - int'(rob_count) >= int'(n_uops)) &&
                (int'(rs_avail) >= int'(n_uops)) &&
                (int'(lb_avail) >= int'(n_ld)) &&
                (int'(sb_avail) >= int'(n_st));
  assign in_ready   = !recovering_q && !mispredict && fits;
  assign accept     = in_valid && in_ready;
  assign flush      = recovering_q && core_drained;
  assign recovering = recovering_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          recovering_q <= 1'b0;
    else if (flush)      recovering_q <= 1'b0;
    else if (mispredict) recovering_q <= 1'b1;
  end

  // ring of in-flight slots with per-slot destination info
  always_comb begin
    for (int k = 0; k < G; k++) begin
      alloc_we[k] = accept && in_uop_vld[k];
      alloc_info[k*INFO_W +: INFO_W] = {in_dst_en[k], in_is_fp[k], in_dst[k*RW +: RW]};
    end
  end

  rat_rob_ring #(.DEPTH(ROB_DEPTH), .G(G), .INFO_W(INFO_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_we(alloc_we), .alloc_tag(slot_tag), .alloc_info(alloc_info),
    .alloc_cnt(accept ? n_uops : GW'(0)), .ret_en(ret_en),
    .tail(tail), .head(head), .count(rob_count),
    .head_info(head_info), .ret_fire(ret_fire)
  );

  // allocation credits
  rat_credit #(.DEPTH(RS_DEPTH), .TW(GW)) u_rs_credit (
    .clk(clk), .rst_n(rst_n), .refill(flush),
    .take(accept ? n_uops : GW'(0)), .give(rs_release), .avail(rs_avail)
  );
  rat_credit #(.DEPTH(LB_DEPTH), .TW(GW)) u_lb_credit (
    .clk(clk), .rst_n(rst_n), .refill(flush),
    .take(accept ? n_ld : GW'(0)), .give(GW'(lb_release)), .avail(lb_avail)
  );
  rat_credit #(.DEPTH(SB_DEPTH), .TW(GW)) u_sb_credit (
    .clk(clk), .rst_n(rst_n), .refill(flush),
    .take(accept ? n_st : GW'(0)), .give(GW'(sb_release)), .avail(sb_avail)
  );

  // read ports: lane k source a on port 2k, source b on port 2k+1
  always_comb begin
    for (int k = 0; k < G; k++) begin
      rd_reg[(2*k)*RW +: RW]   = in_src_a[k*RW +: RW];
      rd_reg[(2*k+1)*RW +: RW] = in_src_b[k*RW +: RW];
    end
  end

  // one alias table per register file
  for (genvar f = 0; f < 2; f++) begin : g_file
    always_comb begin
      for (int k = 0; k < G; k++)
        wr_en_f[f][k] = accept && in_uop_vld[k] && in_dst_en[k] && (in_is_fp[k] == f[0]);
      clr_en_f[f] = ret_fire && head_info[INFO_W-1] && (head_info[INFO_W-2] == f[0]);
    end

    rat_map_table #(.NREG(NREG), .TAG_W(TAG_W), .NWR(G), .NRD(NRD)) u_map (
      .clk(clk), .rst_n(rst_n), .reset_all(flush),
      .wr_en(wr_en_f[f]), .wr_reg(in_dst), .wr_tag(slot_tag),
      .clr_en(clr_en_f[f]), .clr_reg(head_info[RW-1:0]), .clr_tag(head),
      .rd_reg(rd_reg), .rd_inrob(rd_inrob_f[f]), .rd_tag(rd_tag_f[f])
    );
  end

  // source resolution with bypass from earlier lanes of the group
  always_comb begin
    for (int k = 0; k < G; k++) begin
      for (int s = 0; s < 2; s++) begin
        src_inrob[2*k+s] = rd_inrob_f[in_is_fp[k]][2*k+s];
        src_tag[(2*k+s)*TAG_W +: TAG_W] = rd_tag_f[in_is_fp[k]][(2*k+s)*TAG_W +: TAG_W];
        for (int j = 0; j < G; j++) begin
          if (j < k && in_uop_vld[j] && in_dst_en[j] && in_is_fp[j] == in_is_fp[k] &&
              in_dst[j*RW +: RW] == rd_reg[(2*k+s)*RW +: RW]) begin
            src_inrob[2*k+s] = 1'b1;
            src_tag[(2*k+s)*TAG_W +: TAG_W] = slot_tag[j*TAG_W +: TAG_W];
          end
        end
      end
    end
  end

  // registered result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_uop_vld <= '0;
      out_tag     <= '0;
      out_a_tag   <= '0;
      out_b_tag   <= '0;
      out_a_rdy   <= '0;
      out_b_rdy   <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_uop_vld <= in_uop_vld;
        out_tag     <= slot_tag;
        for (int k = 0; k < G; k++) begin
          out_a_tag[k*TAG_W +: TAG_W] <= src_tag[(2*k)*TAG_W +: TAG_W];
          out_b_tag[k*TAG_W +: TAG_W] <= src_tag[(2*k+1)*TAG_W +: TAG_W];
          out_a_rdy[k] <= !src_inrob[2*k];
          out_b_rdy[k] <= !src_inrob[2*k+1];
        end
      end
    end
  end
endmodule

// File: rtl/rat_rename_chk.sv
`timescale 1ns/1ps
module rat_rename_chk #(
  parameter int G         = 3,
  parameter int ROB_DEPTH = 40,
  localparam int TAG_W    = $clog2(ROB_DEPTH),
  localparam int RCW      = $clog2(ROB_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               mispredict,
  input logic               core_drained,
  input logic               recovering,
  input logic               out_valid,
  input logic [G-1:0]       out_uop_vld,
  input logic [G*TAG_W-1:0] out_tag,
  input logic [RCW-1:0]     rob_count
);
  AST_RECOVERY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> !in_ready); // R10
  AST_MISPREDICT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> !in_ready); // R10
  AST_DRAIN_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && core_drained) |=> (!recovering && rob_count == '0)); // R10
  AST_RESULT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R11
  AST_RESULT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready)); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rob_count) <= ROB_DEPTH); // R6
  AST_TAG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_uop_vld[0]) |-> int'(out_tag[TAG_W-1:0]) < ROB_DEPTH); // R2
endmodule

bind rat_rename rat_rename_chk #(.G(G), .ROB_DEPTH(ROB_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mispredict(mispredict), .core_drained(core_drained), .recovering(recovering),
  .out_valid(out_valid), .out_uop_vld(out_uop_vld), .out_tag(out_tag),
  .rob_count(rob_count)
);

// File: tb/rat_rename_test.sv
`timescale 1ns/1ps
module rat_rename_test;
  localparam int G = 3, DEPTH = 40, NREG = 8, RSD = 20, LBD = 16, SBD = 12;
  localparam int TW = 6, RW = 3, GW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid, in_ready, ret_en, lb_release, sb_release, mispredict, core_drained;
  logic [G-1:0] in_uop_vld, in_is_fp, in_dst_en;
  logic [G*RW-1:0] in_dst, in_src_a, in_src_b;
  logic [G*2-1:0] in_mem;
  logic [GW-1:0] rs_release;
  logic out_valid, recovering;
  logic [G-1:0] out_uop_vld, out_a_rdy, out_b_rdy;
  logic [G*TW-1:0] out_tag, out_a_tag, out_b_tag;

  rat_rename uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_uop_vld(in_uop_vld), .in_is_fp(in_is_fp), .in_dst_en(in_dst_en),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_mem(in_mem),
    .ret_en(ret_en), .rs_release(rs_release), .lb_release(lb_release),
    .sb_release(sb_release), .mispredict(mispredict), .core_drained(core_drained),
    .out_valid(out_valid), .out_uop_vld(out_uop_vld), .out_tag(out_tag),
    .out_a_tag(out_a_tag), .out_a_rdy(out_a_rdy), .out_b_tag(out_b_tag),
    .out_b_rdy(out_b_rdy), .recovering(recovering)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // stimulus globals
  bit g_valid, g_ret, g_lb, g_sb, g_mis, g_drn;
  bit g_vld [G], g_fp [G], g_den [G];
  int g_dst [G], g_a [G], g_b [G], g_mem [G], g_rs;

  // reference model
  bit m_inrob [2][NREG];
  int m_tag [2][NREG];
  int r_den [DEPTH], r_fp [DEPTH], r_reg [DEPTH];
  int tail, head, cnt, rs_av, lb_av, sb_av;
  bit recov;

  // expected result of the previous step
  bit pend;
  bit e_vld [G], e_arob [G], e_brob [G];
  int e_tag [G], e_atag [G], e_btag [G];

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int f = 0; f < 2; f++) for (int r = 0; r < NREG; r++) begin
      m_inrob[f][r] = 0; m_tag[f][r] = 0;
    end
    tail = 0; head = 0; cnt = 0; rs_av = RSD; lb_av = LBD; sb_av = SBD; recov = 0;
  endtask

  task automatic idle();
    g_valid = 0; g_ret = 0; g_lb = 0; g_sb = 0; g_mis = 0; g_drn = 0; g_rs = 0;
    for (int k = 0; k < G; k++) begin
      g_vld[k] = 0; g_fp[k] = 0; g_den[k] = 0; g_dst[k] = 0; g_a[k] = 0; g_b[k] = 0; g_mem[k] = 0;
    end
  endtask

  task automatic set_uop(int k, bit fp, bit den, int dst, int a, int b, int mem);
    g_vld[k] = 1; g_fp[k] = fp; g_den[k] = den; g_dst[k] = dst; g_a[k] = a; g_b[k] = b; g_mem[k] = mem;
  endtask

  function automatic int rs_room();
    int u;
    u = RSD - rs_av;
    return (u > 3) ? 3 : u;
  endfunction

  task automatic step();
    int n, nl, ns, off, r, t, f;
    int tg [G];
    bit er, acc, fl, rf, inr;
    @(negedge clk);
    // results of the previous step (R11; tags R2; sources R3 R4 R8 R9)
    if (pend) begin
      chk("R11", "out_valid", out_valid, 1);
      for (int k = 0; k < G; k++) begin
        chk("R11", "out_uop_vld", out_uop_vld[k], e_vld[k]);
        if (e_vld[k]) begin
          chk("R2", "slot tag", out_tag[k*TW +: TW], e_tag[k]);
          chk("R3 R4 R8", "src a ready", out_a_rdy[k], !e_arob[k]);
          if (e_arob[k]) chk("R3 R4 R5", "src a tag", out_a_tag[k*TW +: TW], e_atag[k]);
          chk("R3 R4 R8", "src b ready", out_b_rdy[k], !e_brob[k]);
          if (e_brob[k]) chk("R3 R4 R5", "src b tag", out_b_tag[k*TW +: TW], e_btag[k]);
        end
      end
    end else chk("R11", "out_valid idle", out_valid, 0);

    in_valid = g_valid; ret_en = g_ret; lb_release = g_lb; sb_release = g_sb;
    mispredict = g_mis; core_drained = g_drn; rs_release = GW'(g_rs);
    for (int k = 0; k < G; k++) begin
      in_uop_vld[k] = g_vld[k]; in_is_fp[k] = g_fp[k]; in_dst_en[k] = g_den[k];
      in_dst[k*RW +: RW] = RW'(g_dst[k]); in_src_a[k*RW +: RW] = RW'(g_a[k]);
      in_src_b[k*RW +: RW] = RW'(g_b[k]); in_mem[k*2 +: 2] = 2'(g_mem[k]);
    end
    #1;
    n = 0; nl = 0; ns = 0;
    for (int k = 0; k < G; k++) if (g_vld[k]) begin
      n++;
      if (g_mem[k] == 1) nl++;
      if (g_mem[k] == 2) ns++;
    end
    er = !recov && !g_mis && (DEPTH - cnt >= n) && (rs_av >= n) && (lb_av >= nl) && (sb_av >= ns);
    chk("R6 R10 R12", "in_ready", in_ready, er);
    chk("R10", "recovering", recovering, recov);
    acc = g_valid && er;
    fl = recov && g_drn;
    rf = g_ret && cnt > 0 && !fl;
    pend = acc;
    off = 0;
    for (int k = 0; k < G; k++) begin
      tg[k] = (tail + off) % DEPTH;
      if (g_vld[k]) off++;
    end
    if (acc) begin
      for (int k = 0; k < G; k++) begin
        e_vld[k] = g_vld[k]; e_tag[k] = tg[k];
        for (int s = 0; s < 2; s++) begin
          r = s ? g_b[k] : g_a[k];
          f = g_fp[k];
          inr = m_inrob[f][r]; t = m_tag[f][r];
          if (rf && r_den[head] == 1 && r_fp[head] == f && r_reg[head] == r && inr && t == head) inr = 0;
          for (int j = 0; j < k; j++)
            if (g_vld[j] && g_den[j] && g_fp[j] == f && g_dst[j] == r) begin inr = 1; t = tg[j]; end
          if (s == 0) begin e_arob[k] = inr; e_atag[k] = t; end
          else begin e_brob[k] = inr; e_btag[k] = t; end
        end
      end
    end
    if (fl) model_reset();
    else begin
      if (rf) begin
        if (r_den[head] == 1 && m_inrob[r_fp[head]][r_reg[head]] && m_tag[r_fp[head]][r_reg[head]] == head)
          m_inrob[r_fp[head]][r_reg[head]] = 0;
        head = (head + 1) % DEPTH; cnt--;
      end
      if (acc) begin
        for (int k = 0; k < G; k++) if (g_vld[k]) begin
          r_den[tg[k]] = g_den[k]; r_fp[tg[k]] = g_fp[k]; r_reg[tg[k]] = g_dst[k];
          if (g_den[k]) begin m_inrob[g_fp[k]][g_dst[k]] = 1; m_tag[g_fp[k]][g_dst[k]] = tg[k]; end
        end
        tail = (tail + n) % DEPTH; cnt += n; rs_av -= n; lb_av -= nl; sb_av -= ns;
      end
      rs_av += g_rs; lb_av += g_lb; sb_av += g_sb;
      if (g_mis) recov = 1;
    end
  endtask

  task automatic do_flush();
    idle(); g_mis = 1; step();
    idle(); g_valid = 1; set_uop(0, 0, 1, 1, 1, 1, 0); step(); // R10: blocked while recovering
    idle(); g_drn = 1; step();
    idle();
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    idle(); model_reset(); pend = 0;
    in_valid = 0; ret_en = 0; lb_release = 0; sb_release = 0; mispredict = 0; core_drained = 0;
    rs_release = '0; in_uop_vld = '0; in_is_fp = '0; in_dst_en = '0;
    in_dst = '0; in_src_a = '0; in_src_b = '0; in_mem = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, every register reads from the retirement file
    idle(); step();
    idle(); g_valid = 1; set_uop(0, 0, 0, 0, 7, 3, 0); set_uop(1, 1, 0, 0, 7, 3, 0); step();

    // R4 R5 R9: intra-group bypass, last writer wins, separate files
    idle(); g_valid = 1;
    set_uop(0, 0, 1, 1, 1, 2, 0);
    set_uop(1, 0, 1, 1, 1, 4, 0);
    set_uop(2, 1, 1, 1, 1, 3, 0);
    step();
    idle(); g_valid = 1; set_uop(0, 0, 0, 0, 1, 3, 0); set_uop(1, 1, 0, 0, 1, 2, 0); step();

    // R8: retirement and rename of the same register in one cycle
    do_flush();
    idle(); g_valid = 1; set_uop(0, 0, 1, 5, 0, 0, 0); g_rs = rs_room(); step();
    idle(); g_valid = 1; g_ret = 1; set_uop(0, 0, 0, 0, 5, 5, 0); step();
    idle(); g_valid = 1; set_uop(0, 0, 1, 5, 0, 0, 0); step();
    idle(); g_valid = 1; g_ret = 1; set_uop(0, 0, 1, 5, 5, 5, 0); step();
    idle(); g_valid = 1; set_uop(0, 0, 0, 0, 5, 5, 0); step();

    // R7: a stale retirement leaves the newer mapping
    do_flush();
    idle(); g_valid = 1; set_uop(0, 0, 1, 6, 0, 0, 0); set_uop(1, 0, 1, 6, 0, 0, 0); step();
    idle(); g_ret = 1; step();
    idle(); g_valid = 1; set_uop(0, 0, 0, 0, 6, 6, 0); step();
    idle(); g_ret = 1; step();
    idle(); g_valid = 1; set_uop(0, 0, 0, 0, 6, 6, 0); step();
    // R7: retire on an empty ring is ignored
    do_flush();
    idle(); g_ret = 1; step();
    idle(); g_valid = 1; set_uop(0, 0, 1, 2, 2, 2, 0); step();

    // R6 R2: fill the reorder buffer to the last slot, then wrap
    do_flush();
    for (int i = 0; i < 15; i++) begin
      idle(); g_valid = 1; g_rs = rs_room();
      for (int k = 0; k < G; k++) set_uop(k, 0, 1, k, k + 1, k + 2, 0);
      step();
    end
    idle(); g_valid = 1; g_rs = rs_room(); set_uop(0, 0, 1, 4, 4, 4, 0); step();
    idle(); g_valid = 1; g_rs = rs_room(); set_uop(0, 0, 1, 4, 4, 4, 0); step();
    for (int i = 0; i < 4; i++) begin
      idle(); g_ret = 1; g_rs = rs_room(); step();
    end
    idle(); g_valid = 1; g_rs = rs_room();
    for (int k = 0; k < G; k++) set_uop(k, 1, 1, k, k, 7, 0);
    step();

    // R6 R12: load-queue limit and credit return
    do_flush();
    for (int i = 0; i < 7; i++) begin
      idle(); g_valid = 1; g_rs = rs_room(); g_ret = 1;
      for (int k = 0; k < G; k++) set_uop(k, 0, 0, 0, 0, 0, 1);
      step();
    end
    idle(); g_valid = 1; g_lb = 1; g_rs = rs_room();
    for (int k = 0; k < G; k++) set_uop(k, 0, 0, 0, 0, 0, 1);
    step();
    idle(); g_valid = 1; g_rs = rs_room(); set_uop(0, 0, 0, 0, 0, 0, 1); step();

    // R10: recovery with groups offered during the drain
    idle(); g_valid = 1; g_mis = 1; set_uop(0, 0, 1, 3, 3, 3, 0); step();
    for (int i = 0; i < 3; i++) begin
      idle(); g_valid = 1; g_ret = 1; set_uop(0, 0, 1, 3, 3, 3, 2); step();
    end
    idle(); g_drn = 1; g_valid = 1; g_ret = 1; set_uop(0, 0, 1, 3, 3, 3, 0); step();
    idle(); g_valid = 1; set_uop(0, 0, 0, 0, 3, 1, 0); set_uop(1, 1, 0, 0, 0, 5, 0); step();

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      g_valid = ($urandom % 10) < 7;
      for (int k = 0; k < G; k++) begin
        g_vld[k] = $urandom % 4 != 0; g_fp[k] = $urandom % 3 == 0; g_den[k] = $urandom % 4 != 0;
        g_dst[k] = $urandom % NREG; g_a[k] = $urandom % NREG; g_b[k] = $urandom % NREG;
        g_mem[k] = $urandom % 4; if (g_mem[k] == 3) g_mem[k] = 0;
      end
      g_ret = $urandom % 2;
      g_rs = (rs_room() == 0) ? 0 : $urandom % (rs_room() + 1);
      g_lb = (lb_av < LBD) && ($urandom % 3 == 0);
      g_sb = (sb_av < SBD) && ($urandom % 3 == 0);
      if (recov) g_drn = $urandom % 4 == 0;
      else g_mis = $urandom % 100 == 0;
      if (g_drn) begin g_rs = 0; g_lb = 0; g_sb = 0; end
      step();
    end
    idle(); step(); step();

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule